// File: doc/BRIEF.md
# LZ77 Compression Step Sequencer and Code Formatter

This block drives the compression loop of a sliding-window LZ77 compressor. It fills the look-ahead portion of the window first. After that it repeats a fixed step. It asks an external longest-match finder to search, waits for the finder's result, and decides how to encode that result. It then presents one tagged output item and, once the item is accepted, advances the window by the number of symbols the item consumed.

The match finder returns a pointer into the search window and a match length. A pointer/length codeword costs a whole number of output symbols, so the block emits it only when the match is longer than that cost. In every other case it emits the head symbol of the look-ahead buffer on its own. The most significant bit of each output item tells the two kinds apart. The output is a valid/ready stream that may stall for any number of cycles. Packing items into bytes is left to a downstream stage.

Top module: `lzc_ctrl`

## Requirements
- R1: While reset is held, and after it while `run` is low, `out_valid`, `win_shift`, `mf_start` and `shadow_load` are all 0.
- R2: After `run` rises from idle, `win_shift` is high for exactly LOOK_M cycles before the first `mf_start`.
- R3: A search request is a single-cycle `mf_start` pulse, with `shadow_load` high in the same cycle. No new request is issued until the window has been advanced.
- R4: When the reported length L is greater than CW_SYM, the item is a codeword. CW_SYM is the codeword width PTR_W+LEN_W rounded up to whole symbols. The item's bit ITEM_W-1 is 1, bits LEN_W+PTR_W-1..LEN_W hold the pointer, and bits LEN_W-1..0 hold L.
- R5: When L is at most CW_SYM, the item is a literal. Its bit ITEM_W-1 is 0, its low SYM_W bits hold `head_sym` as captured with `mf_done`, and all other bits are 0.
- R6: After a codeword is accepted, `win_shift` is high for exactly L cycles before the next `mf_start`.
- R7: After a literal is accepted, `win_shift` is high for exactly one cycle before the next `mf_start`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` is unchanged and `win_shift` stays low.
- R9: `win_shift` is low from `mf_start` until the item is accepted. Match inputs that change after the `mf_done` cycle do not alter the item.
- R10: If `run` is low when a step's shift ends, the block goes idle and issues no search. Raising `run` again refills LOOK_M symbols before the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Level request to keep compressing |
| mf_start | output | 1 | Search request pulse to the match finder |
| shadow_load | output | 1 | Copy look-ahead symbols into the finder's shift buffer |
| mf_done | input | 1 | Match finder result valid (one cycle) |
| mf_ptr | input | PTR_W | Best match pointer |
| mf_len | input | LEN_W | Best match length |
| head_sym | input | SYM_W | First look-ahead symbol |
| win_shift | output | 1 | Advance window by one symbol |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Downstream accepts item |
| out_data | output | ITEM_W | Tagged item {flag, payload} |

## Verification
The bench sweeps every pointer and length value of a small configuration. Each value therefore lands on both sides of the threshold, including the exact boundary where L equals CW_SYM. An off-by-one comparison there would swap a codeword for a literal and show up as a wrong flag. The bench also counts window shifts between searches. A sequencer that advanced by L on a literal, or by one on a codeword, would desynchronise the window. The same count catches a fill that is too short or too long. The bench also stalls the output, corrupts the match inputs once they have been captured, and drops `run` in the middle of a step. A design without proper holding registers would then leak changing data, shift during a stall, or keep searching once it has been told to stop.

// File: rtl/lzc_pkg.sv
// Shared types and helpers for the LZ77 step sequencer.
package lzc_pkg;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SEARCH,
        ST_DECIDE,
        ST_EMIT,
        ST_SHIFT
    } lzc_state_t;

    // Number of whole symbols a codeword of cw bits occupies.
    function automatic int cw_symbols(input int cw, input int sw);
        return (cw + sw - 1) / sw;
    endfunction

endpackage

// File: rtl/lzc_decide.sv
// Encoding decision: turns a captured (pointer, length, head symbol) triple
// into a tagged output item and a window advance count.
// Assumes ITEM_W-1 > SYM_W, so a literal fits in the payload field.
module lzc_decide #(
    parameter int SYM_W  = 8,
    parameter int PTR_W  = 9,
    parameter int LEN_W  = 4,
    parameter int CW_SYM = 2,
    localparam int ITEM_W = PTR_W + LEN_W + 1
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SYM_W-1:0]  sym,
    output logic [ITEM_W-1:0] item,
    output logic [LEN_W-1:0]  adv
);
    logic is_code;

    // Anti-expansion rule: compress only if the match beats the codeword cost.
    always_comb is_code = (int'(len) > CW_SYM);

    // Build the item and the advance count for either encoding.
    always_comb begin
        item = '0;
        if (is_code) begin
            item = {1'b1, ptr, len};
            adv  = len;
        end else begin
            item[SYM_W-1:0] = sym;
            adv  = LEN_W'(1);
        end
    end
endmodule

// File: rtl/lzc_hold.sv
// Holding registers: capture the match finder result on done, then the
// encoded item and advance count in the decide cycle. Keeps the output
// stable through downstream stalls regardless of the finder's inputs.
module lzc_hold #(
    parameter int SYM_W  = 8,
    parameter int PTR_W  = 9,
    parameter int LEN_W  = 4,
    localparam int ITEM_W = PTR_W + LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              load_item,
    input  logic [PTR_W-1:0]  ptr_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [SYM_W-1:0]  sym_in,
    input  logic [ITEM_W-1:0] item_in,
    input  logic [LEN_W-1:0]  adv_in,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [SYM_W-1:0]  sym_q,
    output logic [ITEM_W-1:0] item_q,
    output logic [LEN_W-1:0]  adv_q
);
    // Latch the finder's result when it reports done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            len_q <= '0;
            sym_q <= '0;
        end else if (capture) begin
            ptr_q <= ptr_in;
            len_q <= len_in;
            sym_q <= sym_in;
        end
    end

    // Latch the encoded item and its advance count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            item_q <= '0;
            adv_q  <= '0;
        end else if (load_item) begin
            item_q <= item_in;
            adv_q  <= adv_in;
        end
    end
endmodule

// File: rtl/lzc_seq.sv
// Step sequencer: fill, search, decide, emit, shift. Counts shift cycles
// for the initial fill and for each step's advance.
// Assumes LOOK_M >= 2 and every advance count is at least 1.
module lzc_seq
    import lzc_pkg::*;
#(
    parameter int LOOK_M = 16,
    parameter int LEN_W  = 4,
    localparam int CNT_W = $clog2(LOOK_M + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             mf_done,
    input  logic             out_ready,
    input  logic [LEN_W-1:0] adv,
    output logic             mf_start,
    output logic             capture,
    output logic             load_item,
    output logic             out_valid,
    output logic             win_shift
);
    lzc_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             issued;

    // State register, shift counter and search-issued flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            issued <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (run) begin
                    state <= ST_FILL;
                    cnt   <= CNT_W'(LOOK_M);
                end
                ST_FILL: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CNT_W'(1)) begin
                        state  <= ST_SEARCH;
                        issued <= 1'b0;
                    end
                end
                ST_SEARCH: begin
                    issued <= 1'b1;
                    if (issued && mf_done) state <= ST_DECIDE;
                end
                ST_DECIDE: state <= ST_EMIT;
                ST_EMIT: if (out_ready) begin
                    state <= ST_SHIFT;
                    cnt   <= CNT_W'(adv);
                end
                ST_SHIFT: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CNT_W'(1)) begin
                        issued <= 1'b0;
                        state  <= run ? ST_SEARCH : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode per-state control strobes.
    always_comb begin
        mf_start  = (state == ST_SEARCH) && !issued;
        capture   = (state == ST_SEARCH) && issued && mf_done;
        load_item = (state == ST_DECIDE);
        out_valid = (state == ST_EMIT);
        win_shift = (state == ST_FILL) || (state == ST_SHIFT);
    end
endmodule

// File: rtl/lzc_ctrl.sv
// LZ77 compression step controller. Sequences the external match finder,
// applies the anti-expansion rule and streams tagged items:
// {1, pointer, length} for codewords, {0, zeros, symbol} for literals.
// Assumes the window source supplies one symbol per win_shift cycle.
module lzc_ctrl
    import lzc_pkg::*;
#(
    parameter int SYM_W  = 8,
    parameter int WIN_N  = 512,
    parameter int LOOK_M = 16,
    localparam int PTR_W  = $clog2(WIN_N),
    localparam int LEN_W  = $clog2(LOOK_M),
    localparam int CW_W   = PTR_W + LEN_W,
    localparam int CW_SYM = cw_symbols(CW_W, SYM_W),
    localparam int ITEM_W = CW_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic              mf_start,
    output logic              shadow_load,
    input  logic              mf_done,
    input  logic [PTR_W-1:0]  mf_ptr,
    input  logic [LEN_W-1:0]  mf_len,
    input  logic [SYM_W-1:0]  head_sym,
    output logic              win_shift,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ITEM_W-1:0] out_data
);
    logic              capture, load_item;
    logic [PTR_W-1:0]  ptr_q;
    logic [LEN_W-1:0]  len_q, adv_c, adv_q;
    logic [SYM_W-1:0]  sym_q;
    logic [ITEM_W-1:0] item_c;

    lzc_seq #(.LOOK_M(LOOK_M), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .mf_done(mf_done),
        .out_ready(out_ready), .adv(adv_q), .mf_start(mf_start),
        .capture(capture), .load_item(load_item), .out_valid(out_valid),
        .win_shift(win_shift)
    );

    lzc_decide #(.SYM_W(SYM_W), .PTR_W(PTR_W), .LEN_W(LEN_W), .CW_SYM(CW_SYM)) u_dec (
        .ptr(ptr_q), .len(len_q), .sym(sym_q), .item(item_c), .adv(adv_c)
    );

    lzc_hold #(.SYM_W(SYM_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .capture(capture), .load_item(load_item),
        .ptr_in(mf_ptr), .len_in(mf_len), .sym_in(head_sym),
        .item_in(item_c), .adv_in(adv_c),
        .ptr_q(ptr_q), .len_q(len_q), .sym_q(sym_q),
        .item_q(out_data), .adv_q(adv_q)
    );

    // The shift buffer is reloaded in the cycle each search is requested.
    always_comb shadow_load = mf_start;
endmodule

// File: rtl/lzc_ctrl_chk.sv
// Protocol checker for lzc_ctrl, attached by bind.
module lzc_ctrl_chk #(
    parameter int SYM_W  = 8,
    parameter int PTR_W  = 9,
    parameter int LEN_W  = 4,
    parameter int CW_SYM = 2,
    localparam int ITEM_W = PTR_W + LEN_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ITEM_W-1:0] out_data,
    input logic              win_shift,
    input logic              mf_start,
    input logic              shadow_load
);
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_no_shift_emit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !win_shift);

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mf_start |=> !mf_start);

    assert_shadow_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mf_start |-> shadow_load && !win_shift);

    assert_code_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_data[ITEM_W-1] |-> int'(out_data[LEN_W-1:0]) > CW_SYM);

    assert_lit_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_data[ITEM_W-1] |-> (out_data >> SYM_W) == '0);
endmodule

bind lzc_ctrl lzc_ctrl_chk #(
    .SYM_W(SYM_W), .PTR_W(PTR_W), .LEN_W(LEN_W), .CW_SYM(CW_SYM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .win_shift(win_shift), .mf_start(mf_start),
    .shadow_load(shadow_load)
);

// File: tb/sim_lzc_ctrl.sv
// Sweep bench on a small configuration: 4-bit symbols, 16-entry window,
// 8-entry look-ahead, so codewords are 7 bits = 2 symbols.
module sim_lzc_ctrl;
    localparam int SYM_W  = 4;
    localparam int WIN_N  = 16;
    localparam int LOOK_M = 8;
    localparam int PTR_W  = 4;
    localparam int LEN_W  = 3;
    localparam int ITEM_W = 8;
    localparam int CWS    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic mf_done = 1'b0;
    logic out_ready = 1'b0;
    logic [PTR_W-1:0] mf_ptr = '0;
    logic [LEN_W-1:0] mf_len = '0;
    logic [SYM_W-1:0] head_sym = '0;
    logic mf_start, shadow_load, win_shift, out_valid;
    logic [ITEM_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int shift_cnt = 0;
    int start_cnt = 0;
    int base = 0;

    lzc_ctrl #(.SYM_W(SYM_W), .WIN_N(WIN_N), .LOOK_M(LOOK_M)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .mf_start(mf_start),
        .shadow_load(shadow_load), .mf_done(mf_done), .mf_ptr(mf_ptr),
        .mf_len(mf_len), .head_sym(head_sym), .win_shift(win_shift),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always #4 clk = ~clk;

    // Count window shifts and search requests seen at each edge.
    always @(posedge clk) begin
        if (rst_n && win_shift) shift_cnt <= shift_cnt + 1;
        if (rst_n && mf_start)  start_cnt <= start_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_item(input int p, input int l, input int s);
        if (l > CWS) return (1 << (ITEM_W - 1)) | (p << LEN_W) | l;
        return s;
    endfunction

    // One compression step as seen from the finder and the consumer.
    task automatic step(input int p, input int l, input int s, input int stall,
                        input int exp_adv, input string adv_req, input bit drop);
        int exp;
        while (!mf_start) @(negedge clk);
        chk(shift_cnt - base == exp_adv, adv_req, shift_cnt - base, exp_adv);
        chk(shadow_load == 1'b1, "R3", int'(shadow_load), 1);
        base = shift_cnt;
        repeat (2) @(negedge clk);
        chk(mf_start == 1'b0, "R3", int'(mf_start), 0);
        mf_ptr = PTR_W'(p); mf_len = LEN_W'(l); head_sym = SYM_W'(s); mf_done = 1'b1;
        @(negedge clk);
        mf_done = 1'b0;
        mf_ptr = ~PTR_W'(p); mf_len = ~LEN_W'(l); head_sym = ~SYM_W'(s);
        while (!out_valid) @(negedge clk);
        exp = expect_item(p, l, s);
        chk(int'(out_data) == exp, (l > CWS) ? "R4" : "R5", int'(out_data), exp);
        chk(shift_cnt == base, "R9", shift_cnt - base, 0);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(out_valid && int'(out_data) == exp && shift_cnt == base, "R8",
                int'(out_data), exp);
        end
        if (drop) run = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        int prev;
        string rq;
        int st;
        repeat (3) @(negedge clk);
        chk(!out_valid && !win_shift && !mf_start && !shadow_load, "R1", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!out_valid && !win_shift && !mf_start && shift_cnt == 0, "R1", shift_cnt, 0);
        run = 1'b1;
        prev = LOOK_M;
        rq = "R2";
        for (int p = 0; p < WIN_N; p++) begin
            for (int l = 0; l < LOOK_M; l++) begin
                step(p, l, (p * 5 + l) & 15, (p + l) % 3, prev, rq, 1'b0);
                prev = (l > CWS) ? l : 1;
                rq = (l > CWS) ? "R6" : "R7";
            end
        end
        // Stop mid-step: the pending advance completes, then idle.
        step(3, 5, 9, 1, prev, rq, 1'b1);
        st = start_cnt;
        repeat (20) @(negedge clk);
        chk(shift_cnt - base == 5, "R10", shift_cnt - base, 5);
        chk(start_cnt == st && !win_shift, "R10", start_cnt - st, 0);
        run = 1'b1;
        step(1, 2, 6, 0, 5 + LOOK_M, "R10", 1'b0);
        step(2, 7, 3, 2, 1, "R7", 1'b0);
        step(0, 0, 0, 0, 7, "R6", 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R9 actual=hung expected=progress");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule